// File: doc/BRIEF.md
# I2C Write Bridge to a Wishbone Bus

This block is an I2C slave byte engine that turns one fixed-layout I2C write frame into one 32-bit Wishbone master write. A host on the I2C bus sends a device address byte, two bytes of Wishbone address (high byte first) and four data bytes (low byte first). Each accepted byte is acknowledged, and once a stop condition closes a complete frame the block starts a single Wishbone write cycle. It holds that cycle until the bus target answers with ack or err, or until the target has answered with retry for a bounded number of cycles.

The SCL and SDA inputs are expected to be glitch-filtered and synchronous to `clk`. SDA is driven open-drain: `sda_o` is always low and `sda_oe` decides whether the line is pulled. On the Wishbone side, `wb_cyc_o`/`wb_stb_o` act as the request valid and `wb_ack_i` as ready. The request, address and data hold stable until the target accepts or rejects them, so the target applies back-pressure by withholding ack. A frame that completes while an earlier write is still pending is dropped. In practice this cannot happen, because a frame lasts far longer than any bounded bus cycle.

Top module: `i2cwb_bridge`

## Requirements
- R1: After reset `sda_oe`, `wb_cyc_o`, `wb_stb_o` and `wr_done_o` are low.
- R2: Bits of every byte are sampled on the SCL rising edge, least significant bit first. In the first byte, bit 0 is the operation bit (0 = write) and bits 7..1 are the device address.
- R3: The first byte is acknowledged when its operation bit is 0 and its address equals `own_addr` or 0 (general call). To acknowledge, the block raises `sda_oe` on the SCL falling edge that ends bit 7 and drops it on the next falling edge. `sda_oe` is low while any data bit is on the line.
- R4: A first byte with a different address, or with operation bit 1, is not acknowledged. No later byte of that frame is acknowledged, and no Wishbone cycle follows.
- R5: Bytes 2 and 3 give Wishbone address bits 15..8 and 7..0. Bytes 4 to 7 give data bits 7..0, 15..8, 23..16 and 31..24.
- R6: A stop (SDA rising while SCL is high) after seven acknowledged bytes starts a cycle with cyc, stb and we high and sel = 1111. The cycle stays up with stable address and data until ack, err or retry timeout.
- R7: A stop after fewer than seven acknowledged bytes starts no Wishbone cycle.
- R8: Bytes after the seventh are not acknowledged, and the stop still starts the cycle with the first seven bytes.
- R9: `wr_done_o` pulses for exactly one cycle when a cycle ends with ack. A cycle ended by err gives no pulse.
- R10: Retry keeps the cycle up. After RETRY_LIMIT (default 10) sampled cycles with retry the cycle is abandoned with no done pulse. Retry followed by ack before the limit completes normally.
- R11: A start (SDA falling while SCL is high) in the middle of a frame, including a repeated start, discards the partial frame and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA level |
| sda_o | output | 1 | SDA output value, always 0 |
| sda_oe | output | 1 | SDA pull-down enable, high during acknowledge slots |
| own_addr | input | 7 | Device address of this slave |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_sel_o | output | 4 | Wishbone byte select |
| wb_adr_o | output | 16 | Wishbone address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| wb_err_i | input | 1 | Wishbone error |
| wb_rty_i | input | 1 | Wishbone retry |
| wr_done_o | output | 1 | One-cycle pulse on acknowledged write |

## Verification
The bench sends frames whose data bytes are all different. A design that reversed bit order or byte order would then write a scrambled word, and the scoreboard would catch it. It sends a foreign address, a read operation, a frame cut short by stop, an eighth byte and a repeated start in mid-frame. A design that mishandled any of these would acknowledge what it should refuse, issue a cycle that should not exist, or write stale data. On the bus side the target answers with err, with retry that never clears and with retry followed by ack. A faulty retry bound would show up as a cycle of the wrong length, and a faulty completion path as a spurious or missing done pulse.

// File: rtl/i2cwb_pkg.sv
package i2cwb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_BITS,
    FR_ACK,
    FR_SKIP
  } fr_state_e;
endpackage

// File: rtl/i2cwb_line.sv
module i2cwb_line (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  // SDA edges only count as framing while SCL stays high
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cwb_frame.sv
module i2cwb_frame
  import i2cwb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_in,
  input  logic [6:0]        own_addr,
  output logic              sda_oe,
  output logic              fire,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [DATA_W-1:0] frame_data
);
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int DATA_BYTES = DATA_W / BYTE_W;
  localparam int NUM_BYTES  = 1 + ADDR_BYTES + DATA_BYTES;
  localparam int IDX_W      = $clog2(NUM_BYTES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_BYTES);
  localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_BYTES);

  fr_state_e         state;
  logic [3:0]        bit_cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic [BYTE_W-1:0] shreg;
  logic              addr_ok, accept, in_addr;

  assign addr_ok = (shreg[7:1] == own_addr) || (shreg[7:1] == 7'd0);
  assign accept  = (byte_idx == '0) ? (addr_ok && !shreg[0])
                                    : (byte_idx < LAST_IDX);
  assign in_addr = (byte_idx != '0) && (byte_idx <= ADDR_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= FR_IDLE;
      bit_cnt    <= '0;
      byte_idx   <= '0;
      shreg      <= '0;
      sda_oe     <= 1'b0;
      fire       <= 1'b0;
      frame_addr <= '0;
      frame_data <= '0;
    end else begin
      fire <= 1'b0;
      if (start_det) begin
        state    <= FR_BITS;
        bit_cnt  <= '0;
        byte_idx <= '0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        fire   <= (state != FR_IDLE) && (byte_idx == LAST_IDX);
        state  <= FR_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          FR_BITS: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {sda_in, shreg[7:1]};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (accept) begin
                sda_oe   <= 1'b1;
                state    <= FR_ACK;
                byte_idx <= byte_idx + 1'b1;
                if (in_addr)
                  frame_addr <= (frame_addr << BYTE_W) | ADDR_W'(shreg);
                else if (byte_idx != '0)
                  frame_data <= {shreg, frame_data[DATA_W-1:BYTE_W]};
              end else begin
                state <= FR_SKIP;
              end
            end
          end
          FR_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= FR_BITS;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cwb_bus.sv
module i2cwb_bus #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 4,
  parameter int RETRY_LIMIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] frame_addr,
  input  logic [DATA_W-1:0] frame_data,
  output logic              cyc,
  output logic [SEL_W-1:0]  sel,
  output logic [ADDR_W-1:0] adr,
  output logic [DATA_W-1:0] dat,
  input  logic              ack,
  input  logic              err,
  input  logic              rty,
  output logic              done
);
  localparam int RW = $clog2(RETRY_LIMIT + 1);
  localparam logic [RW-1:0] RETRY_END = RW'(RETRY_LIMIT - 1);

  logic          busy;
  logic [RW-1:0] retry_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      retry_cnt <= '0;
      adr       <= '0;
      dat       <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (fire) begin
          busy      <= 1'b1;
          retry_cnt <= '0;
          adr       <= frame_addr;
          dat       <= frame_data;
        end
      end else if (ack) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (err) begin
        busy <= 1'b0;
      end else if (rty) begin
        if (retry_cnt == RETRY_END) busy <= 1'b0;
        else                        retry_cnt <= retry_cnt + 1'b1;
      end
    end
  end

  assign cyc = busy;
  assign sel = busy ? {SEL_W{1'b1}} : '0;
endmodule

// File: rtl/i2cwb_bridge.sv
module i2cwb_bridge #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int RETRY_LIMIT = 10,
  localparam int SEL_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic [6:0]        own_addr,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [DATA_W-1:0] wb_dat_o,
  input  logic              wb_ack_i,
  input  logic              wb_err_i,
  input  logic              wb_rty_i,
  output logic              wr_done_o
);
  logic scl_rise, scl_fall, start_det, stop_det, fire, cyc;
  logic [ADDR_W-1:0] frame_addr;
  logic [DATA_W-1:0] frame_data;

  i2cwb_line u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cwb_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_in(sda_i),
    .own_addr(own_addr), .sda_oe(sda_oe), .fire(fire),
    .frame_addr(frame_addr), .frame_data(frame_data)
  );

  i2cwb_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
              .RETRY_LIMIT(RETRY_LIMIT)) u_bus (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .frame_addr(frame_addr), .frame_data(frame_data),
    .cyc(cyc), .sel(wb_sel_o), .adr(wb_adr_o), .dat(wb_dat_o),
    .ack(wb_ack_i), .err(wb_err_i), .rty(wb_rty_i), .done(wr_done_o)
  );

  assign sda_o    = 1'b0;
  assign wb_cyc_o = cyc;
  assign wb_stb_o = cyc;
  assign wb_we_o  = cyc;
endmodule

// File: rtl/i2cwb_checker.sv
module i2cwb_checker #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int RETRY_LIMIT = 10,
  localparam int SEL_W      = DATA_W / 8,
  localparam int RW         = $clog2(RETRY_LIMIT + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic              wb_we_o,
  input logic [SEL_W-1:0]  wb_sel_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic [DATA_W-1:0] wb_dat_o,
  input logic              wb_ack_i,
  input logic              wb_err_i,
  input logic              wb_rty_i,
  input logic              wr_done_o
);
  logic [RW-1:0] rty_run;

  always_ff @(posedge clk) begin
    if (!rst_n) rty_run <= '0;
    else if (wb_cyc_o && wb_rty_i && !wb_ack_i && !wb_err_i) rty_run <= rty_run + 1'b1;
    else rty_run <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !wb_cyc_o && !sda_oe && !wr_done_o); // R1
  AST_ACK_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !$past(scl_i)); // R3
  AST_REQ_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) wb_cyc_o |-> wb_stb_o && wb_we_o && (wb_sel_o == {SEL_W{1'b1}})); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (wb_cyc_o && !wb_ack_i && !wb_err_i && !wb_rty_i) |=> wb_cyc_o && $stable(wb_adr_o) && $stable(wb_dat_o)); // R6
  AST_DONE_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n) wr_done_o |-> $past(wb_cyc_o && wb_ack_i)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_done_o |=> !wr_done_o); // R9
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (rty_run == RW'(RETRY_LIMIT)) |-> !wb_cyc_o); // R10
endmodule

bind i2cwb_bridge i2cwb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RETRY_LIMIT(RETRY_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
  .wb_sel_o(wb_sel_o), .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o),
  .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i), .wb_rty_i(wb_rty_i),
  .wr_done_o(wr_done_o)
);

// File: tb/i2cwb_bridge_test.sv
`timescale 1ns/1ps
module i2cwb_bridge_test;
  localparam int Q = 6;
  localparam int LIMIT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] own_addr = 7'h2A;
  logic ack_r = 1'b0, err_r = 1'b0, rty_r = 1'b0;
  logic sda_o, sda_oe, cyc, stb, we, done;
  logic [3:0] sel;
  logic [15:0] adr;
  logic [31:0] dat;
  logic sda_line;

  int errors = 0, checks = 0;
  int resp_mode = 0, cyc_len = 0, last_len = 0, cyc_count = 0, done_cnt = 0;
  bit done_prev = 0, finished = 0;
  logic [47:0] exp_q[$];

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~(sda_oe & ~sda_o);

  i2cwb_bridge uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .own_addr(own_addr),
    .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we), .wb_sel_o(sel),
    .wb_adr_o(adr), .wb_dat_o(dat), .wb_ack_i(ack_r), .wb_err_i(err_r),
    .wb_rty_i(rty_r), .wr_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit oe_seen = 0;
    for (int i = 0; i < 8; i++) begin
      sda_m = b[i]; waitq();
      scl_m = 1'b1; waitq();
      if (sda_oe) oe_seen = 1;
      waitq();
      scl_m = 1'b0; waitq();
    end
    chk(!oe_seen, "R3", "sda_oe during data bits", oe_seen, 0);
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    acked = sda_oe;
    waitq();
    scl_m = 1'b0; waitq();
  endtask

  // Sends bytes, checks each acknowledge against expectation
  task automatic send_frame(input logic [7:0] bytes[], input bit exp_ack[],
                            input string req);
    bit a;
    for (int i = 0; i < bytes.size(); i++) begin
      send_byte(bytes[i], a);
      chk(a == exp_ack[i], req, $sformatf("ack of byte %0d", i), a, exp_ack[i]);
    end
  endtask

  // Bus responder and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      ack_r <= 0; err_r <= 0; rty_r <= 0; cyc_len = 0;
    end else begin
      if (done) begin
        done_cnt++;
        if (done_prev) chk(0, "R9", "done pulse longer than one cycle", 1, 0);
      end
      done_prev = done;
      if (cyc) begin
        if (cyc_len == 0) begin
          cyc_count++;
          if (exp_q.size() == 0) chk(0, "R7", "unexpected bus cycle", {adr, dat}, 0);
          else begin
            logic [47:0] e;
            e = exp_q.pop_front();
            chk({adr, dat} == e, "R5", "written address/data", {adr, dat}, e);
            chk(stb && we && sel == 4'hF, "R6", "stb/we/sel", {stb, we, sel}, 6'h3F);
          end
        end
        cyc_len++;
        ack_r <= 0; err_r <= 0; rty_r <= 0;
        case (resp_mode)
          0: ack_r <= (cyc_len == 2);
          1: err_r <= (cyc_len == 2);
          2: rty_r <= 1'b1;
          default: begin rty_r <= (cyc_len <= 3); ack_r <= (cyc_len == 4); end
        endcase
      end else begin
        if (cyc_len != 0) last_len = cyc_len;
        cyc_len = 0;
        ack_r <= 0; err_r <= 0; rty_r <= 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "WD", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c0, d0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!sda_oe && !cyc && !stb && !done, "R1", "outputs in reset",
        {sda_oe, cyc, stb, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sda_oe && !cyc && !done, "R1", "outputs after reset",
        {sda_oe, cyc, done}, 0);

    // R2/R5: full frame, distinct bytes, ack response
    resp_mode = 0; d0 = done_cnt;
    exp_q.push_back({16'h1234, 32'hA5B6C7D8});
    i2c_start();
    send_frame('{8'h54, 8'h12, 8'h34, 8'hD8, 8'hC7, 8'hB6, 8'hA5},
               '{1, 1, 1, 1, 1, 1, 1}, "R3");
    i2c_stop();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "frame issued (LSB-first decode)", exp_q.size(), 0);
    chk(done_cnt == d0 + 1, "R9", "done after ack", done_cnt - d0, 1);
    chk(last_len == 2, "R6", "cycle held until ack", last_len, 2);

    // General call, err response
    resp_mode = 1; d0 = done_cnt;
    exp_q.push_back({16'hFFFF, 32'h0000_0001});
    i2c_start();
    send_frame('{8'h00, 8'hFF, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00},
               '{1, 1, 1, 1, 1, 1, 1}, "R3");
    i2c_stop();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "general call frame issued", exp_q.size(), 0);
    chk(done_cnt == d0, "R9", "no done after err", done_cnt - d0, 0);
    chk(!cyc, "R9", "err ends cycle", cyc, 0);

    // R4: foreign address, then read operation
    c0 = cyc_count;
    i2c_start();
    send_frame('{8'h56, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66},
               '{0, 0, 0, 0, 0, 0, 0}, "R4");
    i2c_stop();
    i2c_start();
    send_frame('{8'h55, 8'h11}, '{0, 0}, "R4");
    i2c_stop();
    repeat (20) @(negedge clk);
    chk(cyc_count == c0, "R4", "no cycle for refused frame", cyc_count - c0, 0);

    // R7: short frame
    i2c_start();
    send_frame('{8'h54, 8'hAB, 8'hCD, 8'h01, 8'h02}, '{1, 1, 1, 1, 1}, "R7");
    i2c_stop();
    repeat (20) @(negedge clk);
    chk(cyc_count == c0, "R7", "no cycle for short frame", cyc_count - c0, 0);

    // R8 eighth byte, R10 retry timeout
    resp_mode = 2; d0 = done_cnt;
    exp_q.push_back({16'h0F0E, 32'h44332211});
    i2c_start();
    send_frame('{8'h54, 8'h0F, 8'h0E, 8'h11, 8'h22, 8'h33, 8'h44, 8'h99},
               '{1, 1, 1, 1, 1, 1, 1, 0}, "R8");
    i2c_stop();
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "cycle issued despite eighth byte", exp_q.size(), 0);
    chk(last_len == LIMIT, "R10", "retry timeout length", last_len, LIMIT);
    chk(done_cnt == d0 && !cyc, "R10", "abandoned without done", done_cnt - d0, 0);

    // R11 repeated start mid-frame, R10 retry then ack
    resp_mode = 3; d0 = done_cnt;
    exp_q.push_back({16'hBEEF, 32'h87654321});
    i2c_start();
    send_frame('{8'h54, 8'h77, 8'h66}, '{1, 1, 1}, "R11");
    i2c_start();
    send_frame('{8'h54, 8'hBE, 8'hEF, 8'h21, 8'h43, 8'h65, 8'h87},
               '{1, 1, 1, 1, 1, 1, 1}, "R11");
    i2c_stop();
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "second frame written", exp_q.size(), 0);
    chk(last_len == 4, "R10", "retry then ack length", last_len, 4);
    chk(done_cnt == d0 + 1, "R10", "done after retry then ack", done_cnt - d0, 1);
    chk(!sda_oe, "R3", "line released after frames", sda_oe, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule